// File: doc/BRIEF.md
# Legacy Keyboard Port Access Trap

This block sits beside the I/O decode path of a host bridge and watches cycles aimed at the two keyboard-controller ports, the data port at 60h and the command/status port at 64h. Every such access is sorted into one of four kinds (data read, data write, command read, command write). Each kind sets a sticky status bit, and so does a level on the USB controller interrupt input. Status is captured ahead of the enable gating, so software sees every access whether or not it is trapped. Any latched source whose enable is on drives the system-management interrupt line (`smi`). A trapped access also keeps the external keyboard controller chip select low, unless the pass-through enable is set.

A small cycle state machine tracks each accepted keyboard access. From `ST_IDLE` an accepted access moves it to `ST_CLASSIFY` (transition "accept"). It then always moves to `ST_COMPLETE` (transition "advance"), where `io_ready` answers the bus. It then returns to `ST_IDLE` (transition "retire"). The status latch is set on the accept edge, so `smi` is already high one cycle before `io_ready` is returned. Software uses a single 16-bit register to read status, write-one-to-clear status bits, and program the enables. A separate route enable copies the raw USB interrupt onto the PCI interrupt D output line.

Top module: `kbd_port_trap`

## Requirements
- R1: An `io_valid` cycle in `ST_IDLE` is accepted when `io_addr` equals 60h or 64h. The access kind sets status bit 0 for a 60h read, bit 1 for a 60h write, bit 2 for a 64h read and bit 3 for a 64h write. Any other address sets no status bit, raises no chip select and returns no `io_ready`.
- R2: A status bit stays set until a register write carries a 1 in that bit position. Writing 0 to a set status bit leaves it set.
- R3: Status bits are latched whatever the enables hold. An access with its enable off still sets its status bit, but `smi` stays low.
- R4: `smi` is high exactly when some status bit 4..0 and its enable bit (12..8 respectively) are both set. It falls in the cycle after the edge on which the clearing write takes effect.
- R5: After the accept edge, `smi` (for an enabled kind) is visible in the next cycle (`ST_CLASSIFY`). `io_ready` is high for exactly one cycle, in the second cycle after accept (`ST_COMPLETE`).
- R6: `kbc_cs` is high in `ST_CLASSIFY` and `ST_COMPLETE` only when the captured kind's enable is off or the pass-through bit 14 is set. It is low in `ST_IDLE`.
- R7: While `usb_irq` is high at a clock edge, status bit 4 sets. Its SMI enable is bit 12.
- R8: `pirq_d` equals `usb_irq` AND route-enable bit 13.
- R9: When a set and a write-one-to-clear hit the same status bit on the same edge, the bit ends set.
- R10: After reset, the register reads 0000h, `smi` is low, `pirq_d` is low and no enable is set, so every later keyboard access raises `kbc_cs`.
- R11: The register reads status in bits 4:0, enables in bits 12:8, route in bit 13 and pass-through in bit 14. Bits 7:5 and 15 read 0, and a register write loads bits 14:8 directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_valid | input | 1 | One-cycle strobe marking a decoded I/O cycle |
| io_write | input | 1 | 1 for a write cycle, 0 for a read |
| io_addr | input | 16 | I/O address of the cycle |
| io_ready | output | 1 | Target-ready answer for an accepted keyboard cycle |
| kbc_cs | output | 1 | Chip select to the external keyboard controller |
| usb_irq | input | 1 | USB controller interrupt level |
| pirq_d | output | 1 | PCI interrupt D line (active high here) |
| smi | output | 1 | System-management interrupt level |
| cfg_wr | input | 1 | Register write strobe |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data |

## Verification
The status latches, enables and state move on the accept or write edge, so `cfg_rdata`, `smi` and `kbc_cs` are due one cycle after the stimulus. `io_ready` is due two cycles after accept, and `pirq_d` follows `usb_irq` in the same cycle. The bench's behavioural model updates on the same edges as the design and compares every output once per clock, one time unit after the falling edge on which inputs change. Each directed check waits for the cycle in which its result is due before it samples.

// File: rtl/kbd_trap_pkg.sv
package kbd_trap_pkg;

    typedef enum logic [1:0] {
        ACC_RD60 = 2'd0,
        ACC_WR60 = 2'd1,
        ACC_RD64 = 2'd2,
        ACC_WR64 = 2'd3
    } acc_kind_t;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_CLASSIFY = 2'd1,
        ST_COMPLETE = 2'd2
    } cyc_state_t;

    localparam int NUM_ACC  = 4;
    localparam int USB_SRC  = NUM_ACC;
    localparam int NUM_SRC  = NUM_ACC + 1;
    localparam int REG_W    = 16;
    localparam int EN_LSB   = 8;
    localparam int ROUTE_B  = 13;
    localparam int PASS_B   = 14;

endpackage

// File: rtl/kbd_trap_decode.sv
module kbd_trap_decode
    import kbd_trap_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] DATA_PORT = 'h60,
    parameter logic [ADDR_W-1:0] CMD_PORT  = 'h64
) (
    input  logic              io_write,
    input  logic [ADDR_W-1:0] io_addr,
    output logic              hit,
    output acc_kind_t         kind,
    output logic [NUM_ACC-1:0] onehot
);

    logic is_data;
    logic is_cmd;

    always_comb begin
        is_data = (io_addr == DATA_PORT);
        is_cmd  = (io_addr == CMD_PORT);
        hit     = is_data | is_cmd;
        unique case ({is_cmd, io_write})
            2'b00:   kind = ACC_RD60;
            2'b01:   kind = ACC_WR60;
            2'b10:   kind = ACC_RD64;
            default: kind = ACC_WR64;
        endcase
        onehot = hit ? (NUM_ACC'(1) << kind) : '0;
    end

endmodule

// File: rtl/kbd_trap_sticky.sv
module kbd_trap_sticky #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q[i] <= 1'b0;
            else if (set_i[i])
                q[i] <= 1'b1;
            else if (clr_i[i])
                q[i] <= 1'b0;
        end

        // R9: a set on the same edge as a clear leaves the bit set
        a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> q[i]);

        // R2: only a clear removes a latched bit
        a_r2_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (q[i] && !clr_i[i]) |=> q[i]);
    end

endmodule

// File: rtl/kbd_trap_cycle_fsm.sv
module kbd_trap_cycle_fsm
    import kbd_trap_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      accept,
    input  acc_kind_t acc_kind,
    output cyc_state_t state,
    output acc_kind_t cur_kind,
    output logic      busy,
    output logic      ready
);

    cyc_state_t state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cur_kind <= ACC_RD60;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && accept)
                cur_kind <= acc_kind;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (accept) state_nx = ST_CLASSIFY;
            ST_CLASSIFY: state_nx = ST_COMPLETE;
            ST_COMPLETE: state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        busy  = (state != ST_IDLE);
        ready = (state == ST_COMPLETE);
    end

    // R5: ready lasts one cycle and follows the classify cycle
    a_r5_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);
    a_r5_ready_after_classify: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> $past(state == ST_CLASSIFY));

endmodule

// File: rtl/kbd_port_trap.sv
module kbd_port_trap
    import kbd_trap_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] DATA_PORT = 'h60,
    parameter logic [ADDR_W-1:0] CMD_PORT  = 'h64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_valid,
    input  logic              io_write,
    input  logic [ADDR_W-1:0] io_addr,
    output logic              io_ready,
    output logic              kbc_cs,
    input  logic              usb_irq,
    output logic              pirq_d,
    output logic              smi,
    input  logic              cfg_wr,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata
);

    logic               dec_hit;
    acc_kind_t          dec_kind;
    logic [NUM_ACC-1:0] dec_onehot;
    logic               accept;
    logic               busy;
    cyc_state_t         state;
    acc_kind_t          cur_kind;
    logic [NUM_SRC-1:0] set_vec;
    logic [NUM_SRC-1:0] clr_vec;
    logic [NUM_SRC-1:0] status;
    logic [NUM_SRC-1:0] enable_q;
    logic               route_q;
    logic               pass_q;

    kbd_trap_decode #(
        .ADDR_W   (ADDR_W),
        .DATA_PORT(DATA_PORT),
        .CMD_PORT (CMD_PORT)
    ) u_decode (
        .io_write(io_write),
        .io_addr (io_addr),
        .hit     (dec_hit),
        .kind    (dec_kind),
        .onehot  (dec_onehot)
    );

    assign accept = io_valid && dec_hit && !busy;

    kbd_trap_cycle_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .acc_kind(dec_kind),
        .state   (state),
        .cur_kind(cur_kind),
        .busy    (busy),
        .ready   (io_ready)
    );

    always_comb begin
        set_vec          = '0;
        set_vec[NUM_ACC-1:0] = accept ? dec_onehot : '0;
        set_vec[USB_SRC] = usb_irq;
        clr_vec          = cfg_wr ? cfg_wdata[NUM_SRC-1:0] : '0;
    end

    kbd_trap_sticky #(.N(NUM_SRC)) u_sticky (
        .clk  (clk),
        .rst_n(rst_n),
        .set_i(set_vec),
        .clr_i(clr_vec),
        .q    (status)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q <= '0;
            route_q  <= 1'b0;
            pass_q   <= 1'b0;
        end else if (cfg_wr) begin
            enable_q <= cfg_wdata[EN_LSB +: NUM_SRC];
            route_q  <= cfg_wdata[ROUTE_B];
            pass_q   <= cfg_wdata[PASS_B];
        end
    end

    always_comb begin
        smi    = |(status & enable_q);
        kbc_cs = busy && (!enable_q[cur_kind] || pass_q);
        pirq_d = usb_irq && route_q;
        cfg_rdata                    = '0;
        cfg_rdata[NUM_SRC-1:0]       = status;
        cfg_rdata[EN_LSB +: NUM_SRC] = enable_q;
        cfg_rdata[ROUTE_B]           = route_q;
        cfg_rdata[PASS_B]            = pass_q;
    end

    // R5: an enabled trapped access has SMI up while ready is returned
    a_r5_smi_before_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COMPLETE && enable_q[cur_kind] && !$past(cfg_wr)) |-> smi);

    // R6: a trapped access without pass-through never reaches the controller
    a_r6_cs_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (kbc_cs && !pass_q) |-> (state != ST_IDLE && !enable_q[cur_kind]));

    // R8: the interrupt route only forwards a live USB interrupt
    a_r8_route_gate: assert property (@(posedge clk) disable iff (!rst_n)
        pirq_d |-> usb_irq);

    // R4: SMI needs some latched source
    a_r4_smi_source: assert property (@(posedge clk) disable iff (!rst_n)
        smi |-> (status != '0));

endmodule

// File: tb/test_kbd_port_trap.sv
module test_kbd_port_trap;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_valid = 1'b0;
    logic        io_write = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_ready;
    logic        kbc_cs;
    logic        usb_irq = 1'b0;
    logic        pirq_d;
    logic        smi;
    logic        cfg_wr = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 0;

    // behavioural reference state
    logic [4:0] m_status = '0;
    logic [4:0] m_en = '0;
    logic       m_route = 0;
    logic       m_pass = 0;
    int         m_phase = 0;
    int         m_kind = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    kbd_port_trap i_kbd_port_trap (
        .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_write(io_write),
        .io_addr(io_addr), .io_ready(io_ready), .kbc_cs(kbc_cs),
        .usb_irq(usb_irq), .pirq_d(pirq_d), .smi(smi), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    always @(posedge clk) begin
        bit acc;
        int k;
        logic [4:0] setv;
        logic [4:0] clrv;
        cycles++;
        if (!rst_n) begin
            m_status = '0; m_en = '0; m_route = 0; m_pass = 0; m_phase = 0; m_kind = 0;
        end else begin
            acc = io_valid && m_phase == 0 && (io_addr == 16'h60 || io_addr == 16'h64);
            k = (io_addr == 16'h64 ? 2 : 0) + (io_write ? 1 : 0);
            setv = '0;
            if (acc) setv[k] = 1'b1;
            if (usb_irq) setv[4] = 1'b1;
            clrv = cfg_wr ? cfg_wdata[4:0] : '0;
            m_status = (m_status & ~clrv) | setv;
            if (cfg_wr) begin
                m_en = cfg_wdata[12:8];
                m_route = cfg_wdata[13];
                m_pass = cfg_wdata[14];
            end
            if (m_phase == 0) begin
                if (acc) begin m_phase = 1; m_kind = k; end
            end else if (m_phase == 1) m_phase = 2;
            else m_phase = 0;
        end
    end

    always @(negedge clk) begin
        logic e_smi, e_cs, e_rdy, e_pirq;
        logic [15:0] e_rd;
        #1;
        if (rst_n && !done) begin
            e_smi = |(m_status & m_en);
            e_cs = (m_phase != 0) && (!m_en[m_kind] || m_pass);
            e_rdy = (m_phase == 2);
            e_pirq = usb_irq && m_route;
            e_rd = {1'b0, m_pass, m_route, m_en, 3'b000, m_status};
            check(smi === e_smi, "R4 smi", smi, e_smi);
            check(kbc_cs === e_cs, "R6 kbc_cs", kbc_cs, e_cs);
            check(io_ready === e_rdy, "R5 io_ready", io_ready, e_rdy);
            check(pirq_d === e_pirq, "R8 pirq_d", pirq_d, e_pirq);
            check(cfg_rdata === e_rd, "R11 cfg_rdata", cfg_rdata, e_rd);
        end
    end

    task automatic settle();
        @(negedge clk); #2;
    endtask

    task automatic cfg(input logic [15:0] d);
        @(negedge clk); cfg_wr = 1'b1; cfg_wdata = d;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic access(input logic [15:0] a, input bit w);
        @(negedge clk); io_valid = 1'b1; io_addr = a; io_write = w;
        @(negedge clk); io_valid = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    always @(posedge clk) begin
        if (cycles > WATCHDOG && !done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, WATCHDOG);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        // R10: reset state
        check(cfg_rdata == 16'h0000, "R10 rdata", cfg_rdata, 0);
        check(smi == 1'b0, "R10 smi", smi, 0);

        // R3/R1: untrapped 60h read latches bit 0, cs passes, no smi
        @(negedge clk); io_valid = 1; io_addr = 16'h60; io_write = 0;
        @(negedge clk); io_valid = 0; #2;
        check(kbc_cs == 1'b1, "R10 cs passes after reset", kbc_cs, 1);
        check(cfg_rdata[0] == 1'b1, "R1 rd60 bit0", cfg_rdata[0], 1);
        check(smi == 1'b0, "R3 status without smi", smi, 0);
        repeat (3) @(negedge clk);

        // R4: enabling exposes the latched bit, clearing drops smi
        cfg(16'h1F00); #2;
        check(smi == 1'b1, "R4 smi after enable", smi, 1);
        cfg(16'h1F00); #2;
        check(cfg_rdata[0] == 1'b1, "R2 write zero keeps bit", cfg_rdata[0], 1);
        cfg(16'h1F01); #2;
        check(smi == 1'b0, "R4 smi after clear", smi, 0);

        // R5/R6: trapped 60h write
        @(negedge clk); io_valid = 1; io_addr = 16'h60; io_write = 1;
        @(negedge clk); io_valid = 0; #2;
        check(smi == 1'b1 && io_ready == 1'b0, "R5 smi before ready", {smi, io_ready}, 2'b10);
        check(kbc_cs == 1'b0, "R6 trapped cs low", kbc_cs, 0);
        settle();
        check(io_ready == 1'b1, "R5 ready in second cycle", io_ready, 1);
        repeat (2) @(negedge clk);
        cfg(16'h1F02);

        // R6: pass-through forces cs on a trapped 64h read
        cfg(16'h5F00);
        @(negedge clk); io_valid = 1; io_addr = 16'h64; io_write = 0;
        @(negedge clk); io_valid = 0; #2;
        check(kbc_cs == 1'b1, "R6 pass-through cs", kbc_cs, 1);
        check(cfg_rdata[2] == 1'b1, "R1 rd64 bit2", cfg_rdata[2], 1);
        repeat (3) @(negedge clk);
        cfg(16'h1F1F);

        // R1: other port ignored
        access(16'h0061, 1'b1);
        #2;
        check(cfg_rdata[4:0] == 5'h0, "R1 other port no status", cfg_rdata[4:0], 0);

        // R9: clear and set of bit 3 on the same edge
        @(negedge clk); io_valid = 1; io_addr = 16'h64; io_write = 1;
        cfg_wr = 1; cfg_wdata = 16'h1F08;
        @(negedge clk); io_valid = 0; cfg_wr = 0; #2;
        check(cfg_rdata[3] == 1'b1, "R9 set beats clear", cfg_rdata[3], 1);
        repeat (3) @(negedge clk);
        cfg(16'h0008);

        // R6: disabled 64h write reaches controller
        @(negedge clk); io_valid = 1; io_addr = 16'h64; io_write = 1;
        @(negedge clk); io_valid = 0; #2;
        check(kbc_cs == 1'b1, "R6 disabled cs high", kbc_cs, 1);
        repeat (3) @(negedge clk);
        cfg(16'h000F);

        // R7/R8: USB interrupt latch and routing
        cfg(16'h3000);
        @(negedge clk); usb_irq = 1; #2;
        check(pirq_d == 1'b1, "R8 routed irq", pirq_d, 1);
        @(negedge clk); usb_irq = 0; #2;
        check(cfg_rdata[4] == 1'b1 && smi == 1'b1, "R7 usb latch and smi", {cfg_rdata[4], smi}, 2'b11);
        check(pirq_d == 1'b0, "R8 irq low", pirq_d, 0);
        cfg(16'h1010); #2;
        check(smi == 1'b0, "R7 usb clear", smi, 0);
        cfg(16'h0000);
        repeat (4) @(negedge clk);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule